// File: doc/BRIEF.md
# Radix-4 Booth Partial Product Generator

This block recodes a signed multiplier word into radix-4 Booth digits and, for each digit, forms a row of weighted partial-product bits from a signed multiplicand. It is meant to feed a carry-save reduction tree, which is not part of this block. The rows need no sign extension. Each row's top bit is complemented and a constant one is placed just above it. The first row instead carries two extension bits.

The two's-complement "+1" that a negative digit needs is not folded into the rows. It is collected in a separate correction word, with each flag at the base column of its own row. Every row is padded to the full product width. When all rows and the correction word are added modulo 2^(XW+YW), the result is the signed product. All outputs are registered once, in the two-process style.

Top module: `booth_pp_gen`

## Requirements
- R1: Row r (r = 0 .. ceil(XW/2)-1) uses the window {p2,p1,p0} = {x[2r+1], x[2r], x[2r-1]}. Here x[-1] is taken as 0, and any index at or above XW reads the sign bit x[XW-1], so an odd XW gives a last window whose top bit repeats the sign.
- R2: Window decode: 000 and 111 mean 0, 001 and 010 mean +1, 011 means +2, 100 means -2, 101 and 110 mean -1.
- R3: Row r holds YW+1 selected bits at columns 2r+j (j = 0..YW). A ±1 digit selects y[j] and a ±2 digit selects y[j-1], with y[YW] the sign bit and y[-1] = 0. A negative digit inverts the selected bit, and a zero digit gives 0. All other columns of a row are 0 unless R5 or R6 says otherwise.
- R4: The correction word has bit 2r equal to p2 AND NOT (p1 AND p0) of row r, which is 1 exactly for negative digits. All its other bits are 0.
- R5: In row 0, column YW+1 repeats the row's column YW, and column YW+2 holds its complement.
- R6: In every row r > 0, the bit at column 2r+YW is the complement of the selected bit, and column 2r+YW+1 holds a constant 1.
- R7: Bits that would land at column XW+YW or above are dropped. The sum of all rows plus the correction word, modulo 2^(XW+YW), equals the signed product x*y.
- R8: Row r is presented on rows_o[r*(XW+YW) +: XW+YW]. Inputs sampled at a rising clock edge appear on the outputs right after that edge and hold until the next edge.
- R9: An asynchronous active-low reset clears rows_o and corr_o to all zeros.
- R10: The parameters may be set to any XW >= 3 and YW >= XW, including odd XW, and the results still follow R1 to R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mplier_i | input | XW | Signed multiplier that is Booth recoded |
| mcand_i | input | YW | Signed multiplicand |
| rows_o | output | ceil(XW/2)*(XW+YW) | Partial-product rows, each padded to the product width |
| corr_o | output | XW+YW | Negation correction bits at each row's base column |

## Verification
Every result is due on the first rising edge after its operands are driven. The bench drives on the falling edge and pushes the expected rows and correction word into a queue. The monitor pops one item per cycle, 1 ns after the next rising edge. A directed check also samples just before that edge, to confirm the outputs still hold the previous item. A second instance with odd XW runs the same stimulus, and every item also has its reduced sum checked against the signed product.

// File: rtl/booth_pp_pkg.sv
package booth_pp_pkg;

    // Decoded radix-4 digit: magnitude selection plus sign.
    typedef struct packed {
        logic neg;   // digit is negative
        logic one;   // magnitude 1
        logic two;   // magnitude 2
    } bdigit_t;

endpackage

// File: rtl/booth_digit_dec.sv
module booth_digit_dec
    import booth_pp_pkg::*;
(
    input  logic [2:0] win_i,   // {p2, p1, p0}
    output bdigit_t    dig_o
);

    always_comb begin
        dig_o = '0;
        unique case (win_i)
            3'b001, 3'b010: dig_o.one = 1'b1;
            3'b011:         dig_o.two = 1'b1;
            3'b100: begin
                dig_o.two = 1'b1;
                dig_o.neg = 1'b1;
            end
            3'b101, 3'b110: begin
                dig_o.one = 1'b1;
                dig_o.neg = 1'b1;
            end
            default:        dig_o = '0;   // 000 and 111: zero digit
        endcase
    end

    // R2: at most one magnitude is selected
    always_comb begin
        p_mag_onehot_r2: assert ($onehot0({dig_o.one, dig_o.two}))
            else $error("digit selects two magnitudes");
    end

    // R4: a negative flag only accompanies a non-zero digit
    always_comb begin
        p_neg_nonzero_r4: assert (!dig_o.neg || dig_o.one || dig_o.two)
            else $error("negative flag on zero digit");
    end

endmodule

// File: rtl/booth_row_gen.sv
module booth_row_gen
    import booth_pp_pkg::*;
#(
    parameter int YW    = 8,
    parameter int PW    = 16,
    parameter int BASE  = 0,
    parameter bit FIRST = 1'b0
) (
    input  logic [YW-1:0] mcand_i,
    input  bdigit_t       dig_i,
    output logic [PW-1:0] row_o
);

    localparam int EW = YW + 2;

    // ext_w[k] = y[k-1]; ext_w[0] = 0, ext_w[YW+1] = sign
    logic [EW-1:0] ext_w;
    logic          sel_v;
    logic          msb_v;

    assign ext_w = {mcand_i[YW-1], mcand_i, 1'b0};

    always_comb begin
        row_o = '0;
        msb_v = 1'b0;
        sel_v = 1'b0;
        for (int j = 0; j <= YW; j++) begin
            sel_v = dig_i.one ? ext_w[j+1] : (dig_i.two ? ext_w[j] : 1'b0);
            sel_v = sel_v ^ dig_i.neg;
            if (j == YW) begin
                msb_v = sel_v;
                if (!FIRST) sel_v = ~sel_v;
            end
            if (BASE + j < PW) row_o[BASE+j] = sel_v;
        end
        if (FIRST) begin
            row_o[YW+1] = msb_v;
            row_o[YW+2] = ~msb_v;
        end else if (BASE + YW + 1 < PW) begin
            row_o[BASE+YW+1] = 1'b1;
        end
    end

endmodule

// File: rtl/booth_pp_gen.sv
module booth_pp_gen
    import booth_pp_pkg::*;
#(
    parameter int XW = 8,
    parameter int YW = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [XW-1:0]           mplier_i,
    input  logic [YW-1:0]           mcand_i,
    output logic [((XW+1)/2)*(XW+YW)-1:0] rows_o,
    output logic [XW+YW-1:0]        corr_o
);

    localparam int PW   = XW + YW;
    localparam int NROW = (XW + 1) / 2;

    typedef struct packed {
        logic [NROW*PW-1:0] rows;
        logic [PW-1:0]      corr;
    } pp_out_t;

    // multiplier with a zero below and the sign repeated above
    logic [XW+1:0]               xext_w;
    bdigit_t [NROW-1:0]          dig_w;
    logic [NROW-1:0][PW-1:0]     row_w;
    pp_out_t                     out_d;
    pp_out_t                     out_q;

    assign xext_w = {mplier_i[XW-1], mplier_i, 1'b0};

    for (genvar r = 0; r < NROW; r++) begin : g_row
        booth_digit_dec u_dec (
            .win_i (xext_w[2*r+2 : 2*r]),
            .dig_o (dig_w[r])
        );
        booth_row_gen #(
            .YW    (YW),
            .PW    (PW),
            .BASE  (2*r),
            .FIRST (r == 0)
        ) u_row (
            .mcand_i (mcand_i),
            .dig_i   (dig_w[r]),
            .row_o   (row_w[r])
        );
    end

    always_comb begin
        out_d      = '0;
        out_d.rows = row_w;
        for (int r = 0; r < NROW; r++) begin
            out_d.corr[2*r] = dig_w[r].neg;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign rows_o = out_q.rows;
    assign corr_o = out_q.corr;

    // ------------------------------------------------------------------
    // Assertions
    // ------------------------------------------------------------------
    function automatic logic [PW-1:0] fold_sum(logic [NROW*PW-1:0] rs,
                                               logic [PW-1:0] cw);
        logic [PW-1:0] acc;
        acc = cw;
        for (int k = 0; k < NROW; k++) acc = acc + rs[k*PW +: PW];
        return acc;
    endfunction

    function automatic logic [PW-1:0] odd_cols();
        logic [PW-1:0] m;
        m = '0;
        for (int k = 1; k < PW; k += 2) m[k] = 1'b1;
        return m;
    endfunction

    localparam logic [PW-1:0] ODD_MASK = odd_cols();

    logic signed [PW-1:0] chk_prod;
    always_comb chk_prod = $signed(mplier_i) * $signed(mcand_i);

    // R7: registered rows and correction reduce to the signed product
    p_sum_product_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (fold_sum(out_q.rows, out_q.corr) == $past(chk_prod)))
        else $error("row sum differs from product");

    // R4: correction bits only at even (row base) columns
    p_corr_even_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_q.corr & ODD_MASK) == '0)
        else $error("correction bit at odd column");

    // R9: outputs are clear while reset is applied
    p_reset_clear_r9: assert property (@(posedge clk)
        !rst_n |=> (out_q == '0))
        else $error("outputs not cleared by reset");

endmodule

// File: tb/booth_pp_gen_tb_top.sv
`timescale 1ns/1ps
module booth_pp_gen_tb_top;

    localparam int AX = 8, AY = 8, AP = 16, AN = 4;
    localparam int BX = 5, BY = 7, BP = 12, BN = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AX-1:0] xa = '0;
    logic [AY-1:0] ya = '0;
    logic [BX-1:0] xb = '0;
    logic [BY-1:0] yb = '0;
    logic [AN*AP-1:0] rows_a;
    logic [AP-1:0]    corr_a;
    logic [BN*BP-1:0] rows_b;
    logic [BP-1:0]    corr_b;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    booth_pp_gen #(.XW(AX), .YW(AY)) dut_i (
        .clk (clk), .rst_n (rst_n), .mplier_i (xa), .mcand_i (ya),
        .rows_o (rows_a), .corr_o (corr_a)
    );

    booth_pp_gen #(.XW(BX), .YW(BY)) dut_b_i (
        .clk (clk), .rst_n (rst_n), .mplier_i (xb), .mcand_i (yb),
        .rows_o (rows_b), .corr_o (corr_b)
    );

    typedef struct {
        logic [15:0]  x;
        logic [15:0]  y;
        logic [127:0] ra;
        logic [15:0]  ca;
        logic [127:0] rb;
        logic [15:0]  cb;
    } item_t;

    item_t sb_q[$];
    logic [AN*AP-1:0] last_rows_a = '0;

    task automatic check(input bit ok, input string req,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference built from the requirements (R1 R2 R3 R4 R5 R6 R7)
    function automatic void model(input int xw, input int yw,
                                  input logic [15:0] x, input logic [15:0] y,
                                  output logic [127:0] rows,
                                  output logic [15:0] corr);
        int pw = xw + yw;
        int nr = (xw + 1) / 2;
        rows = '0;
        corr = '0;
        for (int r = 0; r < nr; r++) begin
            int i = 2 * r;
            int f;
            logic p0, p1, p2, b, yj, ym;
            p0 = (r == 0) ? 1'b0 : x[i-1];
            p1 = x[i];
            p2 = (i + 1 < xw) ? x[i+1] : x[xw-1];
            case ({p2, p1, p0})
                3'b001, 3'b010: f = 1;
                3'b011:         f = 2;
                3'b100:         f = -2;
                3'b101, 3'b110: f = -1;
                default:        f = 0;
            endcase
            corr[i] = (f < 0);
            b = 1'b0;
            for (int j = 0; j <= yw; j++) begin
                yj = (j < yw) ? y[j] : y[yw-1];
                ym = (j == 0) ? 1'b0 : y[j-1];
                b = (f == 1 || f == -1) ? yj : ((f == 2 || f == -2) ? ym : 1'b0);
                if (f < 0) b = ~b;
                if (j == yw && r == 0) begin
                    rows[yw+1] = b;
                    rows[yw+2] = ~b;
                end
                if (j == yw && r > 0) b = ~b;
                if (i + j < pw) rows[r*pw + i + j] = b;
            end
            if (r > 0 && i + yw + 1 < pw) rows[r*pw + i + yw + 1] = 1'b1;
        end
    endfunction

    task automatic drive(input logic [15:0] x, input logic [15:0] y);
        item_t it;
        @(negedge clk);
        xa = x[AX-1:0];
        ya = y[AY-1:0];
        xb = x[BX-1:0];
        yb = y[BY-1:0];
        it.x = x;
        it.y = y;
        model(AX, AY, x, y, it.ra, it.ca);
        model(BX, BY, x, y, it.rb, it.cb);
        sb_q.push_back(it);
    endtask

    // Monitor: each result is due at the first rising edge after driving
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                item_t it;
                logic [15:0] sa;
                logic [11:0] sbv;
                logic signed [15:0] pa;
                logic signed [11:0] pb;
                it = sb_q.pop_front();
                check(rows_a == it.ra[AN*AP-1:0], "R2 R3 rows (8x8)", 128'(rows_a), it.ra);
                check(corr_a == it.ca, "R1 R4 correction (8x8)", 128'(corr_a), 128'(it.ca));
                check(rows_a[AY+1] == rows_a[AY] && rows_a[AY+2] == ~rows_a[AY],
                      "R5 first-row extension", 128'(rows_a[AY+2:AY]), 128'({~rows_a[AY], rows_a[AY], rows_a[AY]}));
                check(rows_a[AP+2+AY+1] == 1'b1 && rows_a[3*AP+6+AY+1] == 1'b1,
                      "R6 constant ones", 128'({rows_a[3*AP+15], rows_a[AP+11]}), 128'(2'b11));
                sa = corr_a;
                for (int k = 0; k < AN; k++) sa = sa + rows_a[k*AP +: AP];
                pa = $signed(it.x[AX-1:0]) * $signed(it.y[AY-1:0]);
                check(sa == pa, "R7 reduced sum (8x8)", 128'(sa), 128'(pa));
                check(rows_b == it.rb[BN*BP-1:0] && corr_b == it.cb[BP-1:0],
                      "R10 odd-width rows and correction",
                      128'({rows_b, corr_b}), 128'({it.rb[BN*BP-1:0], it.cb[BP-1:0]}));
                sbv = corr_b;
                for (int k = 0; k < BN; k++) sbv = sbv + rows_b[k*BP +: BP];
                pb = $signed(it.x[BX-1:0]) * $signed(it.y[BY-1:0]);
                check(sbv == pb, "R7 R10 reduced sum (5x7)", 128'(sbv), 128'(pb));
                last_rows_a = rows_a;
            end
        end
    end

    // Watchdog
    initial begin
        #(5ns * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        lfsr = 16'hACE1;
        // R9: reset state
        @(posedge clk);
        #1;
        check(rows_a == '0 && corr_a == '0 && rows_b == '0 && corr_b == '0,
              "R9 reset state", 128'(rows_a), 128'(0));
        @(negedge clk);
        rst_n = 1'b1;

        // corner operands
        drive(16'h0000, 16'h0000);
        drive(16'h0001, 16'h0001);
        drive(16'hFFFF, 16'hFFFF);
        drive(16'h0080, 16'h0080);
        drive(16'h0080, 16'h007F);
        drive(16'h007F, 16'h0080);
        drive(16'h007F, 16'h007F);
        drive(16'h0010, 16'h0040);   // 5-bit multiplier = -16
        drive(16'h000F, 16'h003F);
        // R2: every window value for row 1 and row 0
        for (int w = 0; w < 8; w++) drive(16'(w << 1), 16'h005A);
        for (int w = 0; w < 4; w++) drive(16'(w), 16'h00A5);

        // R8: outputs hold until the next rising edge
        drive(16'h0000, 16'h0000);
        @(posedge clk);
        #1.5;
        drive(16'h0055, 16'h0033);
        #0.5;
        check(rows_a == last_rows_a, "R8 output holds until edge",
              128'(rows_a), 128'(last_rows_a));

        // pseudo-random sweep
        for (int n = 0; n < 300; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            drive(lfsr, {lfsr[7:0], lfsr[15:8]} ^ 16'(n));
        end

        // R9: reset mid-run
        @(negedge clk);
        while (sb_q.size() > 0) @(negedge clk);
        rst_n = 1'b0;
        #1;
        check(rows_a == '0 && corr_a == '0 && rows_b == '0 && corr_b == '0,
              "R9 asynchronous clear", 128'(rows_a), 128'(0));
        @(negedge clk);
        rst_n = 1'b1;
        drive(16'h00C3, 16'h0081);
        repeat (3) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule